// File: doc/BRIEF.md
# NAND Sector Hamming ECC Corrector

This block checks one 512-byte flash sector against its single-error-correcting Hamming code. It takes two 3-byte codes: the one read back from the spare area and the one recomputed over the data just read. It forms a 32-bit syndrome from the pair and sorts the outcome into one of four classes: clean, one data bit corrected, check bytes damaged, or uncorrectable. For a correctable error it reports which byte of the sector is wrong and which bit within that byte must be inverted.

The block also has a sector buffer with one write port and one read port, sized for block RAM. After a correctable result, reads of the faulty byte come back with the bit already inverted. The stored contents are not rewritten, so the fix is applied on the read path. Any later buffer write, or any later check that is not correctable, removes the fix.

Top module: `nand_ecc_corrector`

## Requirements
- R1: `out_valid` is high for exactly the one cycle after each cycle in which `in_valid` is high, and is low otherwise.
- R2: Each ECC input carries byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. Each code is repacked into a 32-bit word W with W[7:0]=byte0, W[11:8]=byte2[3:0], W[23:16]=byte1, W[27:24]=byte2[7:4] and all other bits zero. The syndrome is the XOR of the two repacked words.
- R3: A zero syndrome gives `status` 0 (clean).
- R4: A syndrome with exactly 12 set bits gives `status` 1 (corrected), with `err_bit` = syndrome[18:16] and `err_byte` = syndrome[27:19].
- R5: A syndrome with exactly one set bit gives `status` 2 (check bytes corrupt).
- R6: Any other nonzero syndrome gives `status` 3 (uncorrectable).
- R7: `err_byte` and `err_bit` are zero whenever `status` is not 1. All result outputs hold their values until the next `in_valid`.
- R8: On reset, `out_valid`, `status`, `err_byte`, `err_bit` and the read-path fix are all cleared.
- R9: The buffer stores `buf_wdata` at `buf_waddr` when `buf_we` is high. `buf_rdata` shows the byte at the `buf_raddr` presented one cycle earlier.
- R10: After a status-1 result, a read of `err_byte` returns the stored byte XOR (1 << `err_bit`). Reads of every other address are unchanged.
- R11: The read-path fix is removed by any buffer write and by any `in_valid` whose result is not status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Both ECC codes are valid this cycle |
| stored_ecc | input | 24 | ECC read from the spare area, byte0 in the low byte |
| calc_ecc | input | 24 | ECC recomputed over the sector data, byte0 in the low byte |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| status | output | 2 | 0 clean, 1 corrected, 2 check bytes corrupt, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the faulty data bit |
| err_bit | output | 3 | Bit index within that byte |
| buf_we | input | 1 | Sector buffer write enable |
| buf_waddr | input | 9 | Sector buffer write address |
| buf_wdata | input | 8 | Sector buffer write data |
| buf_raddr | input | 9 | Sector buffer read address |
| buf_rdata | output | 8 | Read data, corrected on the read path, one cycle latency |

## Verification
The bench walks all 4096 single-data-bit error positions, so every byte and bit index must come out of the correct syndrome field. A design that swapped the nibbles of byte2 during repacking, or took the index one bit off, would point at the wrong location. All 24 single flips of a check bit are tried and must be reported as damaged check bytes. A design that compared the popcount against the wrong constant would instead report them as uncorrectable, or try to correct them. A long pseudo-random sweep of syndrome patterns has its expected class worked out from the popcount in the bench, and this catches errors in the popcount tree for the larger counts. The buffer tests check that the fix lands only on the flagged byte and is dropped after a write or after a clean check. A design that rewrote the buffer, or left a stale fix in place, would return the wrong byte.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = 8 * CODE_BYTES;
  localparam int SYN_W      = 32;
  localparam int BIT_IDX_W  = 3;
  localparam int IDX_LSB    = 16;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_CODEBAD = 2'd2,
    ST_FATAL   = 2'd3
  } ecc_status_e;

  function automatic logic [SYN_W-1:0] repack(input logic [CODE_W-1:0] code);
    logic [SYN_W-1:0] w;
    w        = '0;
    w[7:0]   = code[7:0];
    w[11:8]  = code[19:16];
    w[23:16] = code[15:8];
    w[27:24] = code[23:20];
    return w;
  endfunction

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int N  = 32,
  localparam int LV = $clog2(N),
  localparam int CW = LV + 1
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int NODES = N >> l;
    logic [CW-1:0] s [NODES];
    for (genvar i = 0; i < NODES; i++) begin : g_node
      if (l == 0) begin : g_leaf
        assign s[i] = CW'(vec[i]);
      end else begin : g_add
        assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
      end
    end
  end
  assign count = g_lvl[LV].s[0];
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAIRS        = 12,
  localparam int AW          = $clog2(SECTOR_BYTES),
  localparam int CW          = $clog2(SYN_W) + 1
) (
  input  logic [CODE_W-1:0]    stored,
  input  logic [CODE_W-1:0]    calc,
  output ecc_status_e          kind,
  output logic [AW-1:0]        byte_idx,
  output logic [BIT_IDX_W-1:0] bit_idx
);
  logic [SYN_W-1:0] syn;
  logic [CW-1:0]    weight;

  assign syn = repack(stored) ^ repack(calc);

  ecc_popcount #(.N(SYN_W)) u_pop (
    .vec   (syn),
    .count (weight)
  );

  always_comb begin
    byte_idx = '0;
    bit_idx  = '0;
    if (syn == '0) begin
      kind = ST_CLEAN;
    end else if (weight == CW'(PAIRS)) begin
      kind     = ST_FIXED;
      bit_idx  = syn[IDX_LSB +: BIT_IDX_W];
      byte_idx = syn[IDX_LSB + BIT_IDX_W +: AW];
    end else if (weight == CW'(1)) begin
      kind = ST_CODEBAD;
    end else begin
      kind = ST_FATAL;
    end
  end
endmodule

// File: rtl/ecc_sector_ram.sv
module ecc_sector_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAIRS        = 12,
  parameter int DW           = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [23:0]                     stored_ecc,
  input  logic [23:0]                     calc_ecc,
  output logic                            out_valid,
  output logic [1:0]                      status,
  output logic [$clog2(SECTOR_BYTES)-1:0] err_byte,
  output logic [2:0]                      err_bit,
  input  logic                            buf_we,
  input  logic [$clog2(SECTOR_BYTES)-1:0] buf_waddr,
  input  logic [DW-1:0]                   buf_wdata,
  input  logic [$clog2(SECTOR_BYTES)-1:0] buf_raddr,
  output logic [DW-1:0]                   buf_rdata
);
  localparam int AW = $clog2(SECTOR_BYTES);

  ecc_status_e          c_kind;
  logic [AW-1:0]        c_byte;
  logic [BIT_IDX_W-1:0] c_bit;

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES), .PAIRS(PAIRS)) u_cls (
    .stored   (stored_ecc),
    .calc     (calc_ecc),
    .kind     (c_kind),
    .byte_idx (c_byte),
    .bit_idx  (c_bit)
  );

  // result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      status    <= ST_CLEAN;
      err_byte  <= '0;
      err_bit   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        status   <= c_kind;
        err_byte <= c_byte;
        err_bit  <= c_bit;
      end
    end
  end

  // read-path fix overlay
  logic          fix_valid;
  logic [AW-1:0] fix_addr;
  logic [DW-1:0] fix_mask;
  logic [DW-1:0] rd_mask;
  logic [DW-1:0] ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_valid <= 1'b0;
      fix_addr  <= '0;
      fix_mask  <= '0;
      rd_mask   <= '0;
    end else begin
      if (in_valid) begin
        fix_valid <= (c_kind == ST_FIXED);
        fix_addr  <= c_byte;
        fix_mask  <= DW'(1) << c_bit;
      end else if (buf_we) begin
        fix_valid <= 1'b0;
      end
      rd_mask <= (fix_valid && buf_raddr == fix_addr) ? fix_mask : '0;
    end
  end

  ecc_sector_ram #(.DEPTH(SECTOR_BYTES), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (ram_q)
  );

  assign buf_rdata = ram_q ^ rd_mask;
endmodule

// File: rtl/nand_ecc_corrector_sva.sv
module nand_ecc_corrector_sva #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [23:0]   stored_ecc,
  input logic [23:0]   calc_ecc,
  input logic          out_valid,
  input logic [1:0]    status,
  input logic [AW-1:0] err_byte,
  input logic [2:0]    err_bit
);
  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_equal_is_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stored_ecc == calc_ecc) |=> status == 2'd0);
  a_r4_twelve_fixed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(stored_ecc ^ calc_ecc) == 12) |=> status == 2'd1);
  a_r5_single_codebad: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(stored_ecc ^ calc_ecc) == 1) |=> status == 2'd2);
  a_r7_idx_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && status != 2'd1) |-> (err_byte == '0 && err_bit == '0));
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && status == 2'd0));
endmodule

bind nand_ecc_corrector nand_ecc_corrector_sva #(.AW($clog2(SECTOR_BYTES))) u_sva (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .stored_ecc (stored_ecc),
  .calc_ecc   (calc_ecc),
  .out_valid  (out_valid),
  .status     (status),
  .err_byte   (err_byte),
  .err_bit    (err_bit)
);

// File: tb/nand_ecc_corrector_test.sv
module nand_ecc_corrector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic        out_valid;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic        buf_we = 1'b0;
  logic [8:0]  buf_waddr = '0;
  logic [7:0]  buf_wdata = '0;
  logic [8:0]  buf_raddr = '0;
  logic [7:0]  buf_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nand_ecc_corrector uut (.*);

  // map a 32-bit syndrome word back to the 24-bit flash byte delta
  function automatic logic [23:0] unpack(input logic [31:0] s);
    return {s[27:24], s[11:8], s[23:16], s[7:0]};
  endfunction

  function automatic logic [31:0] spread(input logic [23:0] v);
    logic [31:0] s = '0;
    s[11:0]  = v[11:0];
    s[27:16] = v[23:12];
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply one syndrome pattern and check the classification
  task automatic run(input logic [23:0] st, input logic [31:0] syn, input string req);
    int w;
    logic [1:0] es;
    logic [8:0] eb;
    logic [2:0] ei;
    w  = $countones(syn);
    eb = '0; ei = '0;
    if (syn == 0) es = 2'd0;
    else if (w == 12) begin es = 2'd1; ei = syn[18:16]; eb = syn[27:19]; end
    else if (w == 1) es = 2'd2;
    else es = 2'd3;
    @(negedge clk);
    stored_ecc = st;
    calc_ecc   = st ^ unpack(syn);
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R1 strobe"}, 32'(out_valid), 32'd1);
    check({req, " status"}, 32'(status), 32'(es));
    check({req, " R7 byte"}, 32'(err_byte), 32'(eb));
    check({req, " R7 bit"}, 32'(err_bit), 32'(ei));
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_waddr = a; buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    buf_raddr = a;
    @(negedge clk);
    check(req, 32'(buf_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check("R8 out_valid", 32'(out_valid), 32'd0);
    check("R8 status", 32'(status), 32'd0);
    check("R8 err_byte", 32'(err_byte), 32'd0);
    @(negedge clk);
    check("R1 idle", 32'(out_valid), 32'd0);

    // R3 clean
    run(24'h123456, 32'h0, "R3 clean");
    run(24'hFFFFFF, 32'h0, "R3 clean ones");

    // R2/R4 every single data-bit position
    for (int a = 0; a < 4096; a++) begin
      logic [11:0] ad;
      ad = 12'(a);
      run(24'(a * 40503) ^ 24'h5A5A5A, {4'b0, ad, 4'b0, ~ad}, "R4 fixed");
    end

    // R5 each check bit flipped
    for (int k = 0; k < 24; k++)
      run(24'h0F0F0F, spread(24'(1) << k), "R5 codebad");

    // R6 / mixed patterns
    lfsr = 24'hACE1B5;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      run(lfsr ^ 24'h33CC99, spread(lfsr & (24'(n) * 24'h010307)), "R6 mixed");
    end
    run(24'h0, spread(24'h000003), "R6 two bits");
    run(24'h0, spread(24'hFFFFFF), "R6 all bits");

    // R1 strobe drops after result
    @(negedge clk);
    check("R1 drop", 32'(out_valid), 32'd0);
    check("R7 hold", 32'(status), 32'd3);

    // R9 buffer
    wr(9'd300, 8'hA5);
    wr(9'd301, 8'h3C);
    wr(9'd511, 8'h81);
    rd(9'd300, 8'hA5, "R9 read 300");
    rd(9'd511, 8'h81, "R9 read 511");

    // R10 fix at byte 300 bit 6
    run(24'h000000, {4'b0, 12'(300*8+6), 4'b0, ~12'(300*8+6)}, "R10 set");
    rd(9'd300, 8'hE5, "R10 fixed byte");
    rd(9'd301, 8'h3C, "R10 neighbour");
    rd(9'd511, 8'h81, "R10 far byte");
    // R11 cleared by a clean check
    run(24'h000000, 32'h0, "R11 clean");
    rd(9'd300, 8'hA5, "R11 after clean");
    // R11 cleared by a buffer write
    run(24'h000000, {4'b0, 12'(300*8+6), 4'b0, ~12'(300*8+6)}, "R10 reset");
    rd(9'd300, 8'hE5, "R10 fixed again");
    wr(9'd5, 8'h11);
    rd(9'd300, 8'hA5, "R11 after write");

    // R8 reset mid-run
    run(24'h0, spread(24'h000001), "R5 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 status after reset", 32'(status), 32'd0);
    check("R8 valid after reset", 32'(out_valid), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule